// File: doc/BRIEF.md
# Calendar Clock with Alarm

This block is the timekeeping core of a real-time clock. It holds seconds, minutes, hours, day of week, day of month, month and a two-digit year as an internal binary count. On every accepted one-per-second strobe it advances that count, covering month lengths and leap years. It then presents the time as seven visible byte fields, encoded as BCD or plain binary and with the hour in 24-hour or 12-hour form, as chosen by mode inputs.

A short update window comes before each refresh of the visible fields. During that window an update-in-progress flag is high. When the window closes, the visible fields are refreshed and an update-ended strobe fires. An optional interrupt-request strobe also fires then. Three alarm bytes are compared with the new seconds, minutes and hours. Any alarm byte with both top bits set acts as a wildcard.

Software loads the time through a simple write port. A set-mode input freezes the visible fields while software writes them. The internal count is reloaded from the visible fields when set mode ends. It is also reloaded when a single field is written outside set mode. The surrounding register-bus decoding is not part of this block.

Top module: `cal_clock`

## Requirements
- R1: After reset the visible fields read seconds, minutes, hours and year 0x00 and day of week, day of month and month 0x01. The uip flag and all event strobes are low.
- R2: A sec_tick is accepted only when osc_sel equals 3'b010. With any other osc_sel value a tick changes no field, raises no uip and produces no upd_evt.
- R3: With bin_mode=1 every field reads as a plain binary number. With bin_mode=0 it reads as BCD, with the tens digit in bits 7:4 and the units digit in bits 3:0.
- R4: Seconds and minutes wrap from 59 to 0 and hours from 23 to 0, each carrying into the next field. Day of week counts 1 to 7 and wraps to 1 at midnight. Month wraps from 12 to 1 and carries into the year, and the year wraps from 99 to 00.
- R5: Day of month wraps to 1 after 30 days in months 4, 6, 9 and 11, after 31 days in the other months, and in month 2 after 28 days or 29 days in a leap year. Leap years are taken on the full year CENTURY*100+year (default CENTURY=20, so year 00 is leap): divisible by 4, and either not by 100 or by 400.
- R6: With hr24=0 the hour field holds the encoded value of hour mod 12, with bit 7 set for hours 12 to 23. Hour writes are decoded the same way. With hr24=1 the field holds the hour 0 to 23.
- R7: uip rises the cycle after an accepted tick and stays high for UIP_CYCLES cycles. The visible fields change on the same edge at which uip falls.
- R8: Every accepted tick produces a one-cycle upd_evt at the end of the update window. irq_evt pulses with it when update_ie=1.
- R9: Alarm bytes are written at addresses 7 (seconds), 8 (minutes) and 9 (hours). An alarm byte whose bits 7:6 are 2'b11 matches any value. Any other alarm byte must equal the newly encoded field. When alarm_ie=1 and all three match, alarm_evt and irq_evt pulse with upd_evt. With alarm_ie=0, alarm_evt stays low.
- R10: While set_mode=1 the visible fields are not overwritten by updates and uip stays low. upd_evt is still produced.
- R11: Time fields are written at addresses 0 to 6, in this order: seconds, minutes, hours, day of week, day of month, month, year. Writes to addresses 10 to 15 change nothing. A time-field write with set_mode=0, or a 1-to-0 change of set_mode, reloads the internal time from the visible fields, decoded under the current modes, so the next tick counts on from them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| sec_tick | input | 1 | One-cycle strobe once per second |
| osc_sel | input | 3 | Oscillator control field; 3'b010 runs the clock |
| set_mode | input | 1 | Freezes visible fields for software loading |
| bin_mode | input | 1 | 1 = binary fields, 0 = BCD |
| hr24 | input | 1 | 1 = 24-hour, 0 = 12-hour with PM in bit 7 |
| alarm_ie | input | 1 | Alarm interrupt enable |
| update_ie | input | 1 | Update-ended interrupt enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 8 | Register write data |
| t_sec | output | 8 | Visible seconds |
| t_min | output | 8 | Visible minutes |
| t_hour | output | 8 | Visible hours |
| t_wday | output | 8 | Visible day of week |
| t_mday | output | 8 | Visible day of month |
| t_mon | output | 8 | Visible month |
| t_year | output | 8 | Visible two-digit year |
| uip | output | 1 | Update in progress |
| upd_evt | output | 1 | Update-ended strobe |
| alarm_evt | output | 1 | Alarm-match strobe |
| irq_evt | output | 1 | Interrupt-request strobe |

## Verification
The hardest states to reach from the ports are the calendar edges: the last second of a leap or common February, and the last second of a year 99. Stepping there one tick at a time would take millions of seconds. The stimulus instead loads such instants directly, in set mode or with single-field writes, and then applies one or two ticks. This is done both in directed cases and in a seeded random loop that biases seconds, minutes, hours and day of month toward their upper limits, under all four encoding and hour-mode combinations.

// File: rtl/cal_pkg.sv
package cal_pkg;

   typedef struct packed {
      logic [6:0] year;
      logic [3:0] mon;
      logic [4:0] mday;
      logic [2:0] wday;
      logic [4:0] hour;
      logic [5:0] min;
      logic [5:0] sec;
   } cal_time_t;

   typedef enum logic {SQ_IDLE, SQ_BUSY} seq_state_t;

   localparam int NUM_FIELDS = 7;
   localparam int NUM_ALARMS = 3;

   function automatic logic [7:0] enc8(input logic [6:0] v, input logic bin);
      logic [7:0] w;
      w = {1'b0, v};
      return bin ? w : (((w / 8'd10) << 4) | (w % 8'd10));
   endfunction

   function automatic logic [7:0] dec8(input logic [7:0] v, input logic bin);
      logic [7:0] t;
      t = ({4'd0, v[7:4]} * 8'd10) + {4'd0, v[3:0]};
      return bin ? v : t;
   endfunction

   function automatic logic [7:0] enc_hour(input logic [4:0] h, input logic bin,
                                           input logic h24);
      logic [6:0] w;
      logic       pm;
      w  = {2'b00, h};
      pm = (w >= 7'd12);
      if (h24) return enc8(w, bin);
      return enc8(pm ? (w - 7'd12) : w, bin) | {pm, 7'd0};
   endfunction

   function automatic logic [7:0] dec_hour(input logic [7:0] v, input logic bin,
                                           input logic h24);
      logic [7:0] b;
      b = dec8({1'b0, v[6:0]}, bin);
      if (h24) return dec8(v, bin);
      return v[7] ? (b + 8'd12) : b;
   endfunction

   function automatic logic is_leap(input logic [6:0] yr, input int century);
      int full;
      full = century * 100 + int'(yr);
      return ((full % 4) == 0) && (((full % 100) != 0) || ((full % 400) == 0));
   endfunction

   function automatic logic [4:0] month_len(input logic [3:0] mon, input logic leap);
      case (mon)
         4'd2:                    return leap ? 5'd29 : 5'd28;
         4'd4, 4'd6, 4'd9, 4'd11: return 5'd30;
         default:                 return 5'd31;
      endcase
   endfunction

endpackage

// File: rtl/cal_time_keep.sv
module cal_time_keep
   import cal_pkg::*;
#(
   parameter int CENTURY = 20
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      step,
   input  logic      load,
   input  cal_time_t load_val,
   output cal_time_t cur
);

   cal_time_t  cur_q;
   cal_time_t  nxt;
   logic [4:0] dim;

   always_comb begin
      dim = month_len(cur_q.mon, is_leap(cur_q.year, CENTURY));
      nxt = cur_q;
      if (cur_q.sec < 6'd59) begin
         nxt.sec = cur_q.sec + 6'd1;
      end else begin
         nxt.sec = 6'd0;
         if (cur_q.min < 6'd59) begin
            nxt.min = cur_q.min + 6'd1;
         end else begin
            nxt.min = 6'd0;
            if (cur_q.hour < 5'd23) begin
               nxt.hour = cur_q.hour + 5'd1;
            end else begin
               nxt.hour = 5'd0;
               nxt.wday = (cur_q.wday >= 3'd7) ? 3'd1 : cur_q.wday + 3'd1;
               if (cur_q.mday < dim) begin
                  nxt.mday = cur_q.mday + 5'd1;
               end else begin
                  nxt.mday = 5'd1;
                  if (cur_q.mon < 4'd12) begin
                     nxt.mon = cur_q.mon + 4'd1;
                  end else begin
                     nxt.mon  = 4'd1;
                     nxt.year = (cur_q.year >= 7'd99) ? 7'd0 : cur_q.year + 7'd1;
                  end
               end
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_q <= '{year: 7'd0, mon: 4'd1, mday: 5'd1, wday: 3'd1,
                    hour: 5'd0, min: 6'd0, sec: 6'd0};
      end else if (load) begin
         cur_q <= load_val;
      end else if (step) begin
         cur_q <= nxt;
      end
   end

   assign cur = cur_q;

   // R4
   sec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      step && !load |=> cur_q.sec <= 6'd59);

   // R5
   mday_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      step && !load && cur_q.sec == 6'd59 && cur_q.min == 6'd59 &&
      cur_q.hour == 5'd23 && cur_q.mday >= dim |=> cur_q.mday == 5'd1);

endmodule

// File: rtl/cal_view.sv
module cal_view #(
   parameter int FIELDS = 7,
   parameter int AW     = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   copy,
   input  logic [FIELDS-1:0][7:0] enc_in,
   input  logic                   wr_en,
   input  logic [AW-1:0]          wr_addr,
   input  logic [7:0]             wr_data,
   output logic [FIELDS-1:0][7:0] vis
);

   for (genvar i = 0; i < FIELDS; i++) begin : g_field
      localparam logic [7:0] RST_VAL = (i >= 3 && i <= 5) ? 8'h01 : 8'h00;
      logic hit;
      assign hit = wr_en && (wr_addr == AW'(i));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)    vis[i] <= RST_VAL;
         else if (hit)  vis[i] <= wr_data;
         else if (copy) vis[i] <= enc_in[i];
      end
   end

endmodule

// File: rtl/cal_alarm.sv
module cal_alarm #(
   parameter int NUM = 3,
   parameter int IW  = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [IW-1:0]       wr_idx,
   input  logic [7:0]          wr_data,
   input  logic [NUM-1:0][7:0] cur,
   output logic                hit
);

   logic [NUM-1:0] match;

   for (genvar i = 0; i < NUM; i++) begin : g_cmp
      logic [7:0] alm_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                               alm_q <= 8'h00;
         else if (wr_en && wr_idx == IW'(i))      alm_q <= wr_data;
      end
      assign match[i] = (alm_q[7:6] == 2'b11) || (alm_q == cur[i]);
   end

   assign hit = &match;

endmodule

// File: rtl/cal_clock.sv
module cal_clock
   import cal_pkg::*;
#(
   parameter int         UIP_CYCLES = 8,
   parameter int         CENTURY    = 20,
   parameter logic [2:0] RUN_CODE   = 3'b010
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sec_tick,
   input  logic [2:0] osc_sel,
   input  logic       set_mode,
   input  logic       bin_mode,
   input  logic       hr24,
   input  logic       alarm_ie,
   input  logic       update_ie,
   input  logic       wr_en,
   input  logic [3:0] wr_addr,
   input  logic [7:0] wr_data,
   output logic [7:0] t_sec,
   output logic [7:0] t_min,
   output logic [7:0] t_hour,
   output logic [7:0] t_wday,
   output logic [7:0] t_mday,
   output logic [7:0] t_mon,
   output logic [7:0] t_year,
   output logic       uip,
   output logic       upd_evt,
   output logic       alarm_evt,
   output logic       irq_evt
);

   localparam int CW         = $clog2(UIP_CYCLES + 1);
   localparam int ALM_BASE   = NUM_FIELDS;
   localparam int ALM_IW     = $clog2(NUM_ALARMS);

   if (UIP_CYCLES < 1 || UIP_CYCLES > 4096) begin : g_bad_uip
      $error("cal_clock: UIP_CYCLES out of range");
   end
   if (CENTURY < 0 || CENTURY > 99) begin : g_bad_century
      $error("cal_clock: CENTURY out of range");
   end

   seq_state_t seq_q;
   logic [CW-1:0] cnt_q;
   logic uip_q, set_q, reload_q;
   logic upd_q, alm_q, irq_q;
   logic osc_run, step, finish, wr_time, wr_alarm, alarm_hit;

   cal_time_t cur_t, load_t;
   logic [NUM_FIELDS-1:0][7:0] enc_f, vis_f;
   logic [NUM_ALARMS-1:0][7:0] alm_cur;
   logic [ALM_IW-1:0] alm_idx;

   assign osc_run  = (osc_sel == RUN_CODE);
   assign step     = sec_tick && osc_run && (seq_q == SQ_IDLE) && !reload_q;
   assign finish   = (seq_q == SQ_BUSY) && (cnt_q == '0);
   assign wr_time  = wr_en && (wr_addr < 4'(NUM_FIELDS));
   assign wr_alarm = wr_en && (wr_addr >= 4'(ALM_BASE)) &&
                     (wr_addr < 4'(ALM_BASE + NUM_ALARMS));
   assign alm_idx  = ALM_IW'(wr_addr - 4'(ALM_BASE));

   cal_time_keep #(.CENTURY(CENTURY)) u_keep (
      .clk      (clk),
      .rst_n    (rst_n),
      .step     (step),
      .load     (reload_q),
      .load_val (load_t),
      .cur      (cur_t)
   );

   always_comb begin
      enc_f[0] = enc8({1'b0, cur_t.sec}, bin_mode);
      enc_f[1] = enc8({1'b0, cur_t.min}, bin_mode);
      enc_f[2] = enc_hour(cur_t.hour, bin_mode, hr24);
      enc_f[3] = enc8({4'd0, cur_t.wday}, bin_mode);
      enc_f[4] = enc8({2'd0, cur_t.mday}, bin_mode);
      enc_f[5] = enc8({3'd0, cur_t.mon}, bin_mode);
      enc_f[6] = enc8(cur_t.year, bin_mode);
      alm_cur  = {enc_f[2], enc_f[1], enc_f[0]};
   end

   always_comb begin
      load_t.sec  = 6'(dec8(vis_f[0], bin_mode));
      load_t.min  = 6'(dec8(vis_f[1], bin_mode));
      load_t.hour = 5'(dec_hour(vis_f[2], bin_mode, hr24));
      load_t.wday = 3'(dec8(vis_f[3], bin_mode));
      load_t.mday = 5'(dec8(vis_f[4], bin_mode));
      load_t.mon  = 4'(dec8(vis_f[5], bin_mode));
      load_t.year = 7'(dec8(vis_f[6], bin_mode));
   end

   cal_view #(.FIELDS(NUM_FIELDS), .AW(4)) u_view (
      .clk     (clk),
      .rst_n   (rst_n),
      .copy    (finish && !set_mode),
      .enc_in  (enc_f),
      .wr_en   (wr_time),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .vis     (vis_f)
   );

   cal_alarm #(.NUM(NUM_ALARMS), .IW(ALM_IW)) u_alarm (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_alarm),
      .wr_idx  (alm_idx),
      .wr_data (wr_data),
      .cur     (alm_cur),
      .hit     (alarm_hit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seq_q    <= SQ_IDLE;
         cnt_q    <= '0;
         uip_q    <= 1'b0;
         set_q    <= 1'b0;
         reload_q <= 1'b0;
         upd_q    <= 1'b0;
         alm_q    <= 1'b0;
         irq_q    <= 1'b0;
      end else begin
         set_q    <= set_mode;
         reload_q <= (wr_time && !set_mode) || (set_q && !set_mode);
         upd_q    <= finish;
         alm_q    <= finish && alarm_ie && alarm_hit;
         irq_q    <= finish && ((alarm_ie && alarm_hit) || update_ie);
         if (step) begin
            seq_q <= SQ_BUSY;
            cnt_q <= CW'(UIP_CYCLES - 1);
         end else if (finish) begin
            seq_q <= SQ_IDLE;
         end else if (seq_q == SQ_BUSY) begin
            cnt_q <= cnt_q - 1'b1;
         end
         if (set_mode)    uip_q <= 1'b0;
         else if (step)   uip_q <= 1'b1;
         else if (finish) uip_q <= 1'b0;
      end
   end

   assign {t_year, t_mon, t_mday, t_wday, t_hour, t_min, t_sec} = vis_f;
   assign uip       = uip_q;
   assign upd_evt   = upd_q;
   assign alarm_evt = alm_q;
   assign irq_evt   = irq_q;

   // R2
   osc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !osc_run && !reload_q |=> $stable(cur_t));

   // R10
   set_no_uip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_mode |=> !uip);

   // R10
   set_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_mode && !wr_time |=> $stable(vis_f));

   // R9
   alarm_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      alarm_evt |-> irq_evt && upd_evt);

   // R8
   upd_after_uip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(uip) && !$past(set_mode) |-> upd_evt);

endmodule

// File: tb/test_cal_clock.sv
module test_cal_clock;

   localparam int UIP = 8;

   logic clk = 1'b0, rst_n = 1'b0;
   logic sec_tick = 1'b0;
   logic [2:0] osc_sel = 3'b010;
   logic set_mode = 1'b0, bin_mode = 1'b0, hr24 = 1'b1;
   logic alarm_ie = 1'b0, update_ie = 1'b0;
   logic wr_en = 1'b0;
   logic [3:0] wr_addr = 4'd0;
   logic [7:0] wr_data = 8'd0;
   logic [7:0] t_sec, t_min, t_hour, t_wday, t_mday, t_mon, t_year;
   logic uip, upd_evt, alarm_evt, irq_evt;

   int total = 0, bad = 0;
   int n_upd = 0, n_alm = 0, n_irq = 0, n_uip_set = 0;
   int ms, mm, mh, mwd, mmd, mmo, myr;

   always #10 clk = ~clk;

   cal_clock #(.UIP_CYCLES(UIP), .CENTURY(20)) i_cal_clock (
      .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .osc_sel(osc_sel),
      .set_mode(set_mode), .bin_mode(bin_mode), .hr24(hr24),
      .alarm_ie(alarm_ie), .update_ie(update_ie), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .t_sec(t_sec), .t_min(t_min),
      .t_hour(t_hour), .t_wday(t_wday), .t_mday(t_mday), .t_mon(t_mon),
      .t_year(t_year), .uip(uip), .upd_evt(upd_evt), .alarm_evt(alarm_evt),
      .irq_evt(irq_evt)
   );

   always @(negedge clk) begin
      if (rst_n) begin
         n_upd += int'(upd_evt);
         n_alm += int'(alarm_evt);
         n_irq += int'(irq_evt);
         if (set_mode && uip) n_uip_set++;
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   function automatic int benc(input int v);
      return bin_mode ? v : (((v / 10) << 4) | (v % 10));
   endfunction

   function automatic int benc_hr(input int h);
      if (hr24) return benc(h);
      return benc(h % 12) | ((h >= 12) ? 128 : 0);
   endfunction

   function automatic int bdim(input int mo, input int y);
      int full;
      bit lp;
      full = 2000 + y;
      lp = (full % 4 == 0) && ((full % 100 != 0) || (full % 400 == 0));
      if (mo == 2) return lp ? 29 : 28;
      if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
      return 31;
   endfunction

   task automatic model_adv();
      ms++;
      if (ms == 60) begin
         ms = 0; mm++;
         if (mm == 60) begin
            mm = 0; mh++;
            if (mh == 24) begin
               mh = 0;
               mwd = (mwd == 7) ? 1 : mwd + 1;
               if (mmd >= bdim(mmo, myr)) begin
                  mmd = 1;
                  if (mmo == 12) begin
                     mmo = 1;
                     myr = (myr == 99) ? 0 : myr + 1;
                  end else mmo++;
               end else mmd++;
            end
         end
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input int a, input int d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 4'(a); wr_data = 8'(d);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic load_time(input int s, input int m, input int h, input int wd,
                            input int md, input int mo, input int y);
      ms = s; mm = m; mh = h; mwd = wd; mmd = md; mmo = mo; myr = y;
      @(negedge clk); set_mode = 1'b1;
      wr(0, benc(s)); wr(1, benc(m)); wr(2, benc_hr(h));
      wr(3, benc(wd)); wr(4, benc(md)); wr(5, benc(mo)); wr(6, benc(y));
      @(negedge clk); set_mode = 1'b0;
      cyc(3);
   endtask

   task automatic check_vis(input string req);
      chk({req, " sec"}, int'(t_sec), benc(ms));
      chk({req, " min"}, int'(t_min), benc(mm));
      chk({req, " hour"}, int'(t_hour), benc_hr(mh));
      chk({req, " wday"}, int'(t_wday), benc(mwd));
      chk({req, " mday"}, int'(t_mday), benc(mmd));
      chk({req, " mon"}, int'(t_mon), benc(mmo));
      chk({req, " year"}, int'(t_year), benc(myr));
   endtask

   task automatic tick(input bit runs);
      @(negedge clk); sec_tick = 1'b1;
      @(negedge clk); sec_tick = 1'b0;
      cyc(UIP + 2);
      if (runs) model_adv();
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int u0, a0, i0, hi;
      void'($urandom(32'd1234));
      cyc(3);
      // R1 reset state
      chk("R1 sec", int'(t_sec), 0);   chk("R1 min", int'(t_min), 0);
      chk("R1 hour", int'(t_hour), 0); chk("R1 wday", int'(t_wday), 1);
      chk("R1 mday", int'(t_mday), 1); chk("R1 mon", int'(t_mon), 1);
      chk("R1 year", int'(t_year), 0); chk("R1 uip", int'(uip), 0);
      chk("R1 evt", int'(upd_evt | alarm_evt | irq_evt), 0);
      rst_n = 1'b1;
      cyc(2);

      // R7 window length and visible timing, R4 year rollover in BCD
      load_time(59, 59, 23, 7, 31, 12, 99);
      @(negedge clk); sec_tick = 1'b1;
      @(negedge clk); sec_tick = 1'b0;
      hi = 0;
      while (uip && hi < 100) begin
         hi++;
         if (hi == UIP) chk("R7 old value held", int'(t_sec), benc(59));
         @(negedge clk);
      end
      chk("R7 uip cycles", hi, UIP);
      model_adv();
      chk("R7 updated at uip fall", int'(t_sec), benc(ms));
      cyc(3);
      check_vis("R4 year wrap");

      // R5 leap years
      load_time(59, 59, 23, 2, 28, 2, 0);  tick(1); check_vis("R5 feb 2000");
      load_time(59, 59, 23, 2, 28, 2, 23); tick(1); check_vis("R5 feb 2023");
      load_time(59, 59, 23, 2, 29, 2, 24); tick(1); check_vis("R5 feb 2024");
      load_time(59, 59, 23, 3, 30, 4, 10); tick(1); check_vis("R5 april");

      // R6 12-hour mode
      hr24 = 1'b0;
      load_time(59, 59, 11, 1, 5, 6, 7); tick(1);
      chk("R6 noon", int'(t_hour), 8'h80);
      load_time(59, 59, 22, 1, 5, 6, 7); tick(1);
      chk("R6 eleven pm", int'(t_hour), 8'h91);
      hr24 = 1'b1;

      // R3 binary mode
      bin_mode = 1'b1;
      load_time(59, 44, 13, 4, 19, 9, 57); tick(1);
      check_vis("R3 binary");
      chk("R3 binary min", int'(t_min), 45);
      bin_mode = 1'b0;

      // R2 oscillator hold
      load_time(10, 20, 5, 2, 3, 4, 5);
      u0 = n_upd;
      osc_sel = 3'b000; tick(0); check_vis("R2 hold 000");
      osc_sel = 3'b011; tick(0); check_vis("R2 hold 011");
      chk("R2 no update", n_upd - u0, 0);
      osc_sel = 3'b010;

      // R11 single-field write outside set mode; unused address
      wr(1, benc(30)); mm = 30;
      wr(12, 8'h55);
      cyc(2);
      tick(1); check_vis("R11 reload");

      // R10 set mode freezes visible fields
      @(negedge clk); set_mode = 1'b1;
      wr(0, benc(40)); ms = 40;
      u0 = n_upd;
      tick(0);
      check_vis("R10 frozen");
      chk("R10 uip low", n_uip_set, 0);
      chk("R10 update evt", n_upd - u0, 1);
      @(negedge clk); set_mode = 1'b0;
      cyc(3);
      tick(1); check_vis("R10 R11 reload after set");

      // R8 update interrupt
      u0 = n_upd; i0 = n_irq;
      tick(1);
      chk("R8 upd no irq", n_irq - i0, 0);
      update_ie = 1'b1; tick(1); update_ie = 1'b0;
      chk("R8 irq", n_irq - i0, 1);
      chk("R8 upd count", n_upd - u0, 2);

      // R9 alarms
      load_time(29, 20, 10, 1, 1, 1, 1);
      wr(7, 8'h30); wr(8, 8'h20); wr(9, 8'h10);
      alarm_ie = 1'b1;
      a0 = n_alm; i0 = n_irq;
      tick(1);
      chk("R9 exact match", n_alm - a0, 1);
      chk("R9 match irq", n_irq - i0, 1);
      wr(8, 8'hC0); wr(9, 8'hC5); wr(7, 8'h31);
      a0 = n_alm; tick(1);
      chk("R9 wildcard", n_alm - a0, 1);
      wr(7, 8'h45);
      a0 = n_alm; tick(1);
      chk("R9 mismatch", n_alm - a0, 0);
      wr(7, 8'hC0);
      alarm_ie = 1'b0;
      a0 = n_alm; i0 = n_irq; tick(1);
      chk("R9 disabled", n_alm - a0, 0);
      chk("R9 disabled irq", n_irq - i0, 0);

      // random near-boundary times in all modes (R3 R4 R5 R6)
      for (int it = 0; it < 40; it++) begin
         int s, m, h, mo, y, md, nt;
         bin_mode = 1'($urandom_range(0, 1));
         hr24 = 1'($urandom_range(0, 1));
         s  = $urandom_range(0, 3) == 0 ? $urandom_range(0, 59) : $urandom_range(57, 59);
         m  = $urandom_range(0, 1) == 0 ? 59 : $urandom_range(0, 59);
         h  = $urandom_range(0, 2) == 0 ? $urandom_range(0, 23) : (($urandom_range(0, 1) == 0) ? 23 : 11);
         mo = $urandom_range(1, 12);
         y  = $urandom_range(0, 3) == 0 ? 99 : $urandom_range(0, 99);
         md = $urandom_range(0, 1) == 0 ? bdim(mo, y) : $urandom_range(1, bdim(mo, y));
         load_time(s, m, h, $urandom_range(1, 7), md, mo, y);
         nt = $urandom_range(1, 2);
         for (int k = 0; k < nt; k++) tick(1);
         check_vis("R4 R5 R6 random");
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule